// File: doc/BRIEF.md
# Prioritized Interrupt Collector

This block gathers a set of level-sensitive interrupt lines and turns them into one request for a processor. Every source has its own control word. The word holds an enable bit and a priority level. Among the sources whose line is high, that are enabled, and whose level is not currently in service, a combinational arbiter picks the one on the highest level. When several sources share that level, the lowest source number wins. Software reads the number of the winner from a status word. It enters service by writing that number back to the vector word, which marks the winner's level as busy. It finishes by writing a release mask to the level-acknowledge word.

Every register occupies a group of four words. The first word is a plain read/write view. The other three words are write aliases that OR the written bits in, clear them, or toggle them. A read from any of the four words returns the same value. The control word carries a global output gate and a self-clearing soft-reset bit. Software reaches the block over a simple 32-bit register bus with one cycle of read latency.

Top module: `icoll_top`

## Requirements
- R1: In each four-word register group, the word offset in address bits [3:2] selects the write action: 0 writes the data as is, 1 ORs it in, 2 clears the set data bits, and 3 XORs it in. A read from any of the four offsets returns the register value.
- R2: The byte address map is as follows. The vector word is at 0x000, level-acknowledge at 0x010, control at 0x020 and status at 0x070. The control word for source n is at 0x120 + 0x10*n. In a source word, bit 2 is the enable and bits [1:0] are the priority level. The vector word reads back its last written value.
- R3: The status word returns the number of the winning source. A source qualifies when its input is high, it is enabled, and its level is not busy. Among qualifying sources the higher level wins, and on equal levels the lower source number wins.
- R4: When no source qualifies, the status word reads 0xFFFFFFFF.
- R5: A plain write (offset 0) of a value below 128 to the vector word marks the level of that source busy on the next clock edge. Sources on a busy level do not qualify. A value of 128 or above marks nothing busy.
- R6: A write to any offset of the level-acknowledge word releases every level whose bit is set in data bits [3:0]. Writing 0x1 releases level 0. A read returns the busy levels as a bit mask.
- R7: irq_o is high while control bit 0 is set and some source qualifies. The output follows the source inputs combinationally. Clearing control bit 0 does not change the status word.
- R8: Writing control bit 31 as 1 makes the control word read with bit 31 set during the next cycle. On the clock edge that ends that cycle, all source words, the busy levels, the vector word and the control word return to zero.
- R9: bus_rdata takes the addressed value on the clock edge that ends a read cycle. It holds that value through every cycle that is not a read.
- R10: After rst_n, every register reads zero, the status word reads 0xFFFFFFFF and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Word address, byte address bits [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the edge that ends the read cycle |
| src_i | input | 128 | Level-sensitive interrupt source lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two events can land in the same cycle: a source line rises, and a vector write marks that source's level busy. The bench raises source 12, which is on the level that is about to be taken, in the same cycle that it writes another source's number to the vector word. On the following reads, status must show the lower-level source, not source 12, and irq_o must stay high only because of that lower-level source. The bench also places a read in the single cycle in which a soft reset is pending. That read must still show bit 31 set, and the read after it must see every register cleared.

// File: rtl/icoll_pkg.sv
package icoll_pkg;

  localparam int DATA_W = 32;
  localparam int SRC_EN_BIT = 2;
  localparam int CTRL_RST_BIT = 31;
  localparam logic [DATA_W-1:0] IDLE_CODE = '1;

  // write action selected by address bits [3:2]
  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] alias_apply(input alias_op_e op,
                                                    input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] wd);
    case (op)
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction

endpackage

// File: rtl/icoll_src_bank.sv
module icoll_src_bank
  import icoll_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int LVL_W   = 2,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int FLD_W  = LVL_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           soft_clr,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  alias_op_e                      wr_op,
  input  logic [FLD_W-1:0]               wr_field,  // {enable, level}
  output logic [NUM_SRC-1:0]             en_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]  prio_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic             en_q;
    logic [LVL_W-1:0] lvl_q;
    logic [FLD_W-1:0] fld_nxt;
    logic             hit;

    assign hit     = wr_en && (wr_idx == IDX_W'(g));
    assign fld_nxt = FLD_W'(alias_apply(wr_op, DATA_W'({en_q, lvl_q}), DATA_W'(wr_field)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        lvl_q <= '0;
      end else if (soft_clr) begin
        en_q  <= 1'b0;
        lvl_q <= '0;
      end else if (hit) begin
        en_q  <= fld_nxt[FLD_W-1];
        lvl_q <= fld_nxt[LVL_W-1:0];
      end
    end

    assign en_o[g]   = en_q;
    assign prio_o[g] = lvl_q;
  end

endmodule

// File: rtl/icoll_arbiter.sv
module icoll_arbiter #(
  parameter int NUM_SRC  = 128,
  parameter int LVL_W    = 2,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic [NUM_SRC-1:0]            req,
  input  logic [NUM_SRC-1:0]            en,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] prio,
  input  logic [NUM_LVL-1:0]            busy,
  output logic                          hit,
  output logic [IDX_W-1:0]              win_idx
);

  logic [LVL_W-1:0] best_lvl;

  // ascending scan; strict compare keeps the lowest index on a tie
  always_comb begin
    hit      = 1'b0;
    win_idx  = '0;
    best_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && en[i] && !busy[prio[i]] && (!hit || (prio[i] > best_lvl))) begin
        hit      = 1'b1;
        win_idx  = IDX_W'(i);
        best_lvl = prio[i];
      end
    end
  end

endmodule

// File: rtl/icoll_level_track.sv
module icoll_level_track #(
  parameter int LVL_W    = 2,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               set_en,
  input  logic [LVL_W-1:0]   set_lvl,
  input  logic [NUM_LVL-1:0] ack_mask,
  output logic [NUM_LVL-1:0] busy_o
);

  logic [NUM_LVL-1:0] set_vec;

  assign set_vec = set_en ? (NUM_LVL'(1) << set_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_o <= '0;
    else if (soft_clr) busy_o <= '0;
    else               busy_o <= (busy_o & ~ack_mask) | set_vec;
  end

endmodule

// File: rtl/icoll_top.sv
module icoll_top
  import icoll_pkg::*;
#(
  parameter int NUM_SRC  = 128,
  parameter int LVL_W    = 2,
  parameter int ADDR_W   = 12,
  parameter int SRC_BASE = 'h120,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int RIDX_W  = ADDR_W - 4,
  localparam int FLD_W   = LVL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              irq_o
);

  localparam logic [RIDX_W-1:0] R_VEC  = RIDX_W'(0);
  localparam logic [RIDX_W-1:0] R_ACK  = RIDX_W'(1);
  localparam logic [RIDX_W-1:0] R_CTRL = RIDX_W'(2);
  localparam logic [RIDX_W-1:0] R_STAT = RIDX_W'(7);
  localparam logic [RIDX_W-1:0] R_SRC0 = RIDX_W'(SRC_BASE >> 4);

  // decode
  logic [RIDX_W-1:0] ridx, src_off;
  alias_op_e         op;
  logic              wr, rd, is_vec, is_ack, is_ctrl, is_stat, is_src;
  logic [IDX_W-1:0]  src_idx;

  assign ridx    = bus_addr[ADDR_W-1:4];
  assign op      = alias_op_e'(bus_addr[3:2]);
  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign src_off = ridx - R_SRC0;
  assign is_vec  = (ridx == R_VEC);
  assign is_ack  = (ridx == R_ACK);
  assign is_ctrl = (ridx == R_CTRL);
  assign is_stat = (ridx == R_STAT);
  assign is_src  = (ridx >= R_SRC0) && ((RIDX_W+1)'(src_off) < (RIDX_W+1)'(NUM_SRC));
  assign src_idx = src_off[IDX_W-1:0];

  // named internal events
  logic [NUM_SRC-1:0]            en_w;
  logic [NUM_SRC-1:0][LVL_W-1:0] prio_w;
  logic [NUM_LVL-1:0]            busy_w;
  logic [NUM_LVL-1:0]            ack_mask;
  logic                          win_hit;
  logic [IDX_W-1:0]              win_idx;
  logic                          svc_enter;
  logic [IDX_W-1:0]              svc_idx;
  logic [LVL_W-1:0]              svc_lvl;
  logic                          soft_clr;

  logic [DATA_W-1:0] vec_q;
  logic              ctrl_en_q, ctrl_rst_q;

  assign svc_enter = wr && is_vec && (op == OP_WR) && (bus_wdata < DATA_W'(NUM_SRC));
  assign svc_idx   = bus_wdata[IDX_W-1:0];
  assign svc_lvl   = prio_w[svc_idx];
  assign ack_mask  = (wr && is_ack) ? bus_wdata[NUM_LVL-1:0] : '0;
  assign soft_clr  = ctrl_rst_q;

  icoll_src_bank #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .wr_en    (wr && is_src),
    .wr_idx   (src_idx),
    .wr_op    (op),
    .wr_field ({bus_wdata[SRC_EN_BIT], bus_wdata[LVL_W-1:0]}),
    .en_o     (en_w),
    .prio_o   (prio_w)
  );

  icoll_level_track #(.LVL_W(LVL_W)) i_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .set_en   (svc_enter),
    .set_lvl  (svc_lvl),
    .ack_mask (ack_mask),
    .busy_o   (busy_w)
  );

  icoll_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_arb (
    .req     (src_i),
    .en      (en_w),
    .prio    (prio_w),
    .busy    (busy_w),
    .hit     (win_hit),
    .win_idx (win_idx)
  );

  // vector and control words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q      <= '0;
      ctrl_en_q  <= 1'b0;
      ctrl_rst_q <= 1'b0;
    end else if (ctrl_rst_q) begin
      vec_q      <= '0;
      ctrl_en_q  <= 1'b0;
      ctrl_rst_q <= 1'b0;
    end else if (wr) begin
      if (is_vec) vec_q <= alias_apply(op, vec_q, bus_wdata);
      if (is_ctrl) begin
        ctrl_en_q  <= 1'(alias_apply(op, DATA_W'(ctrl_en_q), DATA_W'(bus_wdata[0])));
        ctrl_rst_q <= 1'(alias_apply(op, DATA_W'(ctrl_rst_q), DATA_W'(bus_wdata[CTRL_RST_BIT])));
      end
    end
  end

  // read path
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (is_vec)       rd_val = vec_q;
    else if (is_ack)  rd_val = DATA_W'(busy_w);
    else if (is_ctrl) begin
      rd_val[0]            = ctrl_en_q;
      rd_val[CTRL_RST_BIT] = ctrl_rst_q;
    end
    else if (is_stat) rd_val = win_hit ? DATA_W'(win_idx) : IDLE_CODE;
    else if (is_src) begin
      rd_val[SRC_EN_BIT]  = en_w[src_idx];
      rd_val[LVL_W-1:0]   = prio_w[src_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
  end

  assign irq_o = ctrl_en_q && win_hit;

endmodule

// File: rtl/icoll_chk.sv
module icoll_chk #(
  parameter int NUM_SRC  = 128,
  parameter int LVL_W    = 2,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int NUM_LVL = 1 << LVL_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_valid,
  input logic                          bus_write,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_SRC-1:0]            src_i,
  input logic                          irq_o,
  input logic [NUM_SRC-1:0]            en_w,
  input logic [NUM_SRC-1:0][LVL_W-1:0] prio_w,
  input logic [NUM_LVL-1:0]            busy_w,
  input logic [NUM_LVL-1:0]            ack_mask,
  input logic                          win_hit,
  input logic [IDX_W-1:0]              win_idx,
  input logic                          svc_enter,
  input logic [LVL_W-1:0]              svc_lvl,
  input logic                          soft_clr
);

  // R8
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (busy_w == '0 && en_w == '0 && !irq_o && !soft_clr));

  // R5
  svc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_enter && !soft_clr) |=> busy_w[$past(svc_lvl)]);

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask != '0 && !soft_clr && !svc_enter) |=> ((busy_w & $past(ack_mask)) == '0));

  // R3
  win_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (src_i[win_idx] && en_w[win_idx] && !busy_w[prio_w[win_idx]]));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind icoll_top icoll_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_rdata (bus_rdata),
  .src_i     (src_i),
  .irq_o     (irq_o),
  .en_w      (en_w),
  .prio_w    (prio_w),
  .busy_w    (busy_w),
  .ack_mask  (ack_mask),
  .win_hit   (win_hit),
  .win_idx   (win_idx),
  .svc_enter (svc_enter),
  .svc_lvl   (svc_lvl),
  .soft_clr  (soft_clr)
);

// File: tb/test_icoll_top.sv
`timescale 1ns/1ps
module test_icoll_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0;
  logic         bus_write = 1'b0;
  logic [11:2]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] src_i = '0;
  logic         irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  icoll_top i_icoll_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_i     (src_i),
    .irq_o     (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // drivers: entered at a falling edge, return at a falling edge
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[11:2]; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[11:2];
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: pops the expected value for each read and compares
  initial begin
    forever begin
      @(posedge clk);
      if (bus_valid && !bus_write) begin
        @(negedge clk);
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 irq low after reset", 32'(irq_o), 0);
    bus_rd(12'h070, 32'hFFFF_FFFF, "R4 R10 idle status");
    bus_rd(12'h020, 0, "R10 control zero");
    bus_rd(12'h010, 0, "R10 no busy level");

    // R2 R1 source 5 word and aliases
    bus_wr(12'h170, 32'h6);
    bus_rd(12'h170, 32'h6, "R2 source word plain");
    bus_wr(12'h174, 32'h1);
    bus_rd(12'h178, 32'h7, "R1 set alias");
    bus_wr(12'h178, 32'h4);
    bus_rd(12'h17C, 32'h3, "R1 clear alias");
    bus_wr(12'h17C, 32'h5);
    bus_rd(12'h174, 32'h6, "R1 toggle alias");

    // R7 output gating
    bus_wr(12'h020, 32'h1);
    check("R7 nothing pending", 32'(irq_o), 0);
    src_i[5] = 1'b1; #1;
    check("R7 pending source raises irq", 32'(irq_o), 1);
    bus_rd(12'h070, 5, "R3 single source");

    // R3 ordering
    bus_wr(12'h1B0, 32'h7);
    src_i[9] = 1'b1;
    bus_rd(12'h070, 9, "R3 higher level wins");
    bus_wr(12'h150, 32'h7);
    src_i[3] = 1'b1;
    bus_rd(12'h070, 3, "R3 tie goes to lowest number");

    bus_wr(12'h028, 32'h1);
    check("R7 global gate off", 32'(irq_o), 0);
    bus_rd(12'h070, 3, "R7 status unaffected by gate");
    bus_wr(12'h024, 32'h1);
    check("R7 global gate on", 32'(irq_o), 1);

    // R5 service entry colliding with a new request on the same level
    bus_wr(12'h1E0, 32'h7);
    src_i[12] = 1'b1;
    bus_wr(12'h000, 3);
    bus_rd(12'h070, 5, "R5 busy level skipped");
    check("R5 irq from lower level only", 32'(irq_o), 1);
    bus_rd(12'h010, 32'h8, "R6 busy mask read");
    bus_rd(12'h000, 3, "R2 vector readback");

    // R6 release
    bus_wr(12'h010, 32'h1);
    bus_rd(12'h070, 5, "R6 other level untouched");
    bus_rd(12'h010, 32'h8, "R6 level 3 still busy");
    bus_wr(12'h01C, 32'h8);
    bus_rd(12'h070, 3, "R6 release via toggle alias");

    bus_wr(12'h000, 200);
    bus_rd(12'h010, 0, "R5 out of range vector marks nothing");

    // R2 enable bit masking
    bus_wr(12'h158, 32'h4);
    bus_rd(12'h070, 9, "R2 masked source skipped");
    bus_wr(12'h1B8, 32'h4);
    bus_wr(12'h1E8, 32'h4);
    bus_rd(12'h070, 5, "R2 remaining source");

    bus_wr(12'h000, 5);
    bus_rd(12'h070, 32'hFFFF_FFFF, "R4 all candidates busy");
    check("R7 irq low when nothing qualifies", 32'(irq_o), 0);

    // R9 hold across a write
    bus_wr(12'h010, 32'h4);
    check("R9 rdata held across write", bus_rdata, 32'hFFFF_FFFF);
    bus_rd(12'h070, 5, "R6 level 2 released");

    // R8 soft reset, read placed in the pending cycle
    bus_wr(12'h020, 32'h8000_0001);
    bus_rd(12'h020, 32'h8000_0001, "R8 reset bit visible one cycle");
    bus_rd(12'h020, 0, "R8 control cleared");
    bus_rd(12'h170, 0, "R8 source word cleared");
    bus_rd(12'h000, 0, "R8 vector cleared");
    bus_rd(12'h070, 32'hFFFF_FFFF, "R8 nothing enabled");
    check("R8 irq low", 32'(irq_o), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule